// File: doc/BRIEF.md
# Codec Host Bus and Dual DMA Interface

This block is the byte-wide host-side slave of an audio codec. The host bus is asynchronous and has active-low chip select, read and write strobes, a 2-bit address and an 8-bit data path. The block samples that bus into the system clock domain. Register cycles reach four direct slots: an index, an indexed data window into a file of 37 internal control registers, a flag/status slot and a slot that always reads zero.

Two DMA channels work at the same time. The capture channel drains a sample FIFO that the converter side fills. The playback channel fills a sample FIFO that the converter side empties. Each channel has its own active-high request and active-low acknowledge. The converter side sees plain valid/ready ports.

The block also drives the enable and direction pins of an external data transceiver. It derives them directly from the strobes, the chip select and the acknowledges.

Top module: `hostbus_codec_if`

## Requirements
- R1: `cap_req` is high exactly while the capture FIFO holds at least one byte. It goes high on the clock after a sample-side push into an empty FIFO. It goes low after the pop that empties the FIFO.
- R2: `pb_req` is high while the playback FIFO has free space. It goes low once the FIFO holds `DEPTH` bytes.
- R3: A read strobe while `cap_ack_n` is low is a DMA read. During the strobe `data_out` shows the oldest capture byte. On the strobe's rising edge exactly one byte is popped. Chip select and address are ignored.
- R4: A write strobe while `pb_ack_n` is low is a DMA write. On the strobe's rising edge exactly one byte is pushed into the playback FIFO. Chip select is ignored.
- R5: With no acknowledge low, a strobe acts only while `cs_n` is low. Without it, a write changes no register and a read leaves `data_oe` low.
- R6: `xcvr_en_n` is low exactly while (`rd_n` or `wr_n` is low) and (`cs_n`, `cap_ack_n` or `pb_ack_n` is low). Otherwise it is high.
- R7: `xcvr_dir` is low exactly while `rd_n` is low together with `cs_n`, `cap_ack_n` or `pb_ack_n` low. Otherwise it is high.
- R8: Register write to address 0 sets the index, and reading address 0 returns it. Address 1 reads or writes the internal register that the index selects.
- R9: An index of 37 or more reads as 0x00 through address 1, and writes to it are discarded.
- R10: A DMA read from an empty capture FIFO repeats the last byte popped and sets a sticky underrun flag (status bit 0).
- R11: A DMA write to a full playback FIFO is dropped and sets a sticky overrun flag (status bit 1). Writing address 2 with bit 0 or bit 1 set clears the matching flag. Status bit 2 mirrors `cap_req` and bit 3 mirrors `pb_req`.
- R12: Playback bytes leave on `pb_out_data` in the order they were written.
- R13: After reset both FIFOs are empty, `cap_req` is 0, `pb_req` is 1, `xcvr_en_n` and `xcvr_dir` are 1, and the index, every internal register and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select for register cycles, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| adr | input | 2 | Direct register address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data |
| data_oe | output | 1 | High while the block drives read data |
| cap_ack_n | input | 1 | Capture DMA acknowledge, active low |
| pb_ack_n | input | 1 | Playback DMA acknowledge, active low |
| cap_req | output | 1 | Capture DMA request |
| pb_req | output | 1 | Playback DMA request |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward the block |
| cap_in_valid | input | 1 | Capture sample valid |
| cap_in_ready | output | 1 | Capture FIFO can take a byte |
| cap_in_data | input | 8 | Capture sample byte |
| pb_out_valid | output | 1 | Playback byte available |
| pb_out_ready | input | 1 | Converter side takes the byte |
| pb_out_data | output | 8 | Playback sample byte |

## Verification
A FIFO count that has gone wrong shows up on the request pins on the very next clock. The request either stays high on an empty capture FIFO or drops while playback space remains. A strobe edge counted twice pops or pushes an extra byte. That skips a byte on the next DMA read, or puts a duplicate into the playback stream the scoreboard compares. A corrupted index or flag shows up on the next register read of addresses 0, 1 or 2, one bus cycle later.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  localparam logic [1:0] ADR_INDEX = 2'd0;
  localparam logic [1:0] ADR_DATA  = 2'd1;
  localparam logic [1:0] ADR_STAT  = 2'd2;

  // status layout: {4'b0, pb_req, cap_req, overrun, underrun}
  function automatic logic [7:0] pack_status(input logic und, input logic ovr,
                                             input logic creq, input logic preq);
    return {4'b0000, preq, creq, ovr, und};
  endfunction

  function automatic logic idx_in_range(input int unsigned idx, input int unsigned n);
    return idx < n;
  endfunction
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbc_fifo.sv
module hbc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign rdata   = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hbc_regfile.sv
module hbc_regfile #(
  parameter int NUM_REGS = 37,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  import hbc_pkg::*;
  logic [7:0] regs [NUM_REGS];
  logic       hit;

  assign hit   = idx_in_range(32'(idx), NUM_REGS);
  assign rdata = hit ? regs[idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'h00;
    end else if (we && hit) begin
      regs[idx] <= wdata;
    end
  end
endmodule

// File: rtl/hostbus_codec_if.sv
module hostbus_codec_if #(
  parameter int DEPTH    = 16,
  parameter int NUM_REGS = 37
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] adr,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  input  logic       cap_ack_n,
  input  logic       pb_ack_n,
  output logic       cap_req,
  output logic       pb_req,
  output logic       xcvr_en_n,
  output logic       xcvr_dir,
  input  logic       cap_in_valid,
  output logic       cap_in_ready,
  input  logic [7:0] cap_in_data,
  output logic       pb_out_valid,
  input  logic       pb_out_ready,
  output logic [7:0] pb_out_data
);
  import hbc_pkg::*;

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int SW    = 15;
  localparam logic [SW-1:0] SYNC_RST = {5'b11111, 2'b00, 8'h00};

  // transceiver controls straight from the bus pins
  logic any_sel, any_strobe;
  assign any_sel    = !cs_n || !cap_ack_n || !pb_ack_n;
  assign any_strobe = !rd_n || !wr_n;
  assign xcvr_en_n  = !(any_strobe && any_sel);
  assign xcvr_dir   = !(!rd_n && any_sel);

  // synchronized bus bundle
  logic [SW-1:0] s_bus;
  hbc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({rd_n, wr_n, cs_n, cap_ack_n, pb_ack_n, adr, data_in}),
    .q(s_bus)
  );

  logic       s_rd_n, s_wr_n, s_cs_n, s_cak_n, s_pak_n;
  logic [1:0] s_adr;
  logic [7:0] s_dat;
  assign {s_rd_n, s_wr_n, s_cs_n, s_cak_n, s_pak_n, s_adr, s_dat} = s_bus;

  // qualifiers latched while a synchronized strobe is low
  logic       d_rd_n, d_wr_n;
  logic       q_cs, q_cak, q_pak;
  logic [1:0] q_adr;
  logic [7:0] q_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_rd_n <= 1'b1;
      d_wr_n <= 1'b1;
      q_cs   <= 1'b0;
      q_cak  <= 1'b0;
      q_pak  <= 1'b0;
      q_adr  <= '0;
      q_dat  <= '0;
    end else begin
      d_rd_n <= s_rd_n;
      d_wr_n <= s_wr_n;
      if (!s_rd_n || !s_wr_n) begin
        q_cs  <= !s_cs_n;
        q_cak <= !s_cak_n;
        q_pak <= !s_pak_n;
        q_adr <= s_adr;
        q_dat <= s_dat;
      end
    end
  end

  // named bus events, one per completed strobe
  logic rd_rise, wr_rise;
  logic ev_dma_rd, ev_dma_wr, ev_pio_wr;
  assign rd_rise   = s_rd_n && !d_rd_n;
  assign wr_rise   = s_wr_n && !d_wr_n;
  assign ev_dma_rd = rd_rise && q_cak;
  assign ev_dma_wr = wr_rise && q_pak;
  assign ev_pio_wr = wr_rise && !q_pak && !q_cak && q_cs;

  // capture FIFO
  logic          cap_push, cap_pop, cap_full, cap_empty;
  logic [7:0]    cap_head;
  logic [CW-1:0] cap_level;
  assign cap_in_ready = !cap_full;
  assign cap_push     = cap_in_valid && cap_in_ready;
  assign cap_pop      = ev_dma_rd && !cap_empty;

  hbc_fifo #(.W(8), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .push(cap_push), .wdata(cap_in_data),
    .pop(cap_pop), .rdata(cap_head),
    .full(cap_full), .empty(cap_empty), .level(cap_level)
  );

  // playback FIFO
  logic          pb_push, pb_pop, pb_full, pb_empty;
  logic [CW-1:0] pb_level;
  assign pb_push      = ev_dma_wr && !pb_full;
  assign pb_out_valid = !pb_empty;
  assign pb_pop       = pb_out_valid && pb_out_ready;

  hbc_fifo #(.W(8), .DEPTH(DEPTH)) u_pb (
    .clk(clk), .rst_n(rst_n),
    .push(pb_push), .wdata(q_dat),
    .pop(pb_pop), .rdata(pb_out_data),
    .full(pb_full), .empty(pb_empty), .level(pb_level)
  );

  assign cap_req = !cap_empty;
  assign pb_req  = !pb_full;

  // last popped capture byte and sticky flags
  logic [7:0] last_cap;
  logic       cap_underrun, pb_overrun;
  logic       und_set, ovr_set, und_clr, ovr_clr;
  assign und_set = ev_dma_rd && cap_empty;
  assign ovr_set = ev_dma_wr && pb_full;
  assign und_clr = ev_pio_wr && (q_adr == ADR_STAT) && q_dat[0];
  assign ovr_clr = ev_pio_wr && (q_adr == ADR_STAT) && q_dat[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cap     <= 8'h00;
      cap_underrun <= 1'b0;
      pb_overrun   <= 1'b0;
    end else begin
      if (cap_pop) last_cap <= cap_head;
      if (und_set)      cap_underrun <= 1'b1;
      else if (und_clr) cap_underrun <= 1'b0;
      if (ovr_set)      pb_overrun <= 1'b1;
      else if (ovr_clr) pb_overrun <= 1'b0;
    end
  end

  // index register and indirect file
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       reg_rdata;
  logic             idx_we, reg_we;
  assign idx_we = ev_pio_wr && (q_adr == ADR_INDEX);
  assign reg_we = ev_pio_wr && (q_adr == ADR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= q_dat[IDX_W-1:0];
  end

  hbc_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .idx(idx_q), .wdata(q_dat), .rdata(reg_rdata)
  );

  // read path: a DMA acknowledge takes precedence over chip select
  always_comb begin
    if (!cap_ack_n) begin
      data_out = cap_empty ? last_cap : cap_head;
    end else begin
      unique case (adr)
        ADR_INDEX: data_out = 8'(idx_q);
        ADR_DATA:  data_out = reg_rdata;
        ADR_STAT:  data_out = pack_status(cap_underrun, pb_overrun, cap_req, pb_req);
        default:   data_out = 8'h00;
      endcase
    end
  end
  assign data_oe = !rd_n && (!cap_ack_n || (pb_ack_n && !cs_n));
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_n,
  input logic          cs_n,
  input logic          xcvr_en_n,
  input logic          xcvr_dir,
  input logic          cap_req,
  input logic          pb_req,
  input logic          cap_push,
  input logic          ev_dma_rd,
  input logic          ev_dma_wr,
  input logic [CW-1:0] pb_level,
  input logic          pb_pop,
  input logic          cap_underrun,
  input logic          und_clr
);
  localparam logic [CW-1:0] ONE_SHORT = CW'(DEPTH-1);

  assert_capreq_after_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_push |=> cap_req);

  assert_pbreq_drop_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dma_wr && pb_level == ONE_SHORT && !pb_pop) |=> !pb_req);

  assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_rd |=> !ev_dma_rd);

  assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_wr |=> !ev_dma_wr);

  assert_enable_on_reg_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !cs_n) |-> !xcvr_en_n);

  assert_dir_low_only_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_dir |-> !rd_n);

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_underrun && !und_clr) |=> cap_underrun);
endmodule

bind hostbus_codec_if hbc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .cs_n(cs_n),
  .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
  .cap_req(cap_req), .pb_req(pb_req), .cap_push(cap_push),
  .ev_dma_rd(ev_dma_rd), .ev_dma_wr(ev_dma_wr),
  .pb_level(pb_level), .pb_pop(pb_pop),
  .cap_underrun(cap_underrun), .und_clr(und_clr)
);

// File: tb/sim_hostbus_codec_if.sv
`timescale 1ns/1ps
module sim_hostbus_codec_if;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] adr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       cap_ack_n = 1'b1, pb_ack_n = 1'b1;
  logic       cap_req, pb_req, xcvr_en_n, xcvr_dir;
  logic       cap_in_valid = 1'b0;
  logic       cap_in_ready;
  logic [7:0] cap_in_data = '0;
  logic       pb_out_valid;
  logic       pb_out_ready = 1'b0;
  logic [7:0] pb_out_data;

  always #2 clk = ~clk;

  hostbus_codec_if #(.DEPTH(DEPTH), .NUM_REGS(37)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .adr(adr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .cap_ack_n(cap_ack_n), .pb_ack_n(pb_ack_n),
    .cap_req(cap_req), .pb_req(pb_req),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
    .cap_in_valid(cap_in_valid), .cap_in_ready(cap_in_ready), .cap_in_data(cap_in_data),
    .pb_out_valid(pb_out_valid), .pb_out_ready(pb_out_ready), .pb_out_data(pb_out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int drained = 0;
  bit done = 1'b0;
  logic [7:0] cap_q[$];
  logic [7:0] pb_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one host bus cycle; also checks transceiver pins mid-strobe (R6, R7)
  task automatic bus(input bit rd, input bit cs, input bit cak, input bit pak,
                     input logic [1:0] a, input logic [7:0] d,
                     output logic [7:0] rdat, output logic oe);
    bit sel;
    @(posedge clk); #1;
    cs_n = !cs; cap_ack_n = !cak; pb_ack_n = !pak; adr = a; data_in = d;
    repeat (3) @(posedge clk); #1;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    rdat = data_out;
    oe   = data_oe;
    sel  = cs || cak || pak;
    chk("R6 xcvr_en_n", 32'(xcvr_en_n), 32'(!sel));
    chk("R7 xcvr_dir", 32'(xcvr_dir), 32'(!(rd && sel)));
    repeat (6) @(posedge clk); #1;
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    cs_n = 1'b1; cap_ack_n = 1'b1; pb_ack_n = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] r; logic o;
    bus(1'b0, 1'b1, 1'b0, 1'b0, a, d, r, o);
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] r);
    logic o;
    bus(1'b1, 1'b1, 1'b0, 1'b0, a, 8'h00, r, o);
  endtask

  task automatic cap_feed(input logic [7:0] d);
    @(posedge clk); #1;
    cap_in_valid = 1'b1; cap_in_data = d;
    @(posedge clk); #1;
    cap_in_valid = 1'b0;
    cap_q.push_back(d);
  endtask

  task automatic pb_send(input logic [7:0] d, input bit expect_keep);
    logic [7:0] r; logic o;
    bus(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, d, r, o);
    if (expect_keep) pb_q.push_back(d);
  endtask

  // playback monitor: compares drained bytes against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && pb_out_valid && pb_out_ready) begin
      drained++;
      if (pb_q.size() == 0) chk("R12 unexpected playback byte", 32'(pb_out_data), 32'hFFFF);
      else chk("R12 playback order", 32'(pb_out_data), 32'(pb_q.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic o;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    chk("R13 cap_req", 32'(cap_req), 0);
    chk("R13 pb_req", 32'(pb_req), 1);
    chk("R13 xcvr_en_n", 32'(xcvr_en_n), 1);
    chk("R13 xcvr_dir", 32'(xcvr_dir), 1);
    reg_rd(2'd2, r); chk("R13 status", 32'(r), 32'h08);
    reg_rd(2'd0, r); chk("R13 index", 32'(r), 0);
    reg_rd(2'd1, r); chk("R13 reg0", 32'(r), 0);

    // R8 direct and indirect access
    reg_wr(2'd0, 8'd5);  reg_wr(2'd1, 8'h3C);
    reg_rd(2'd0, r); chk("R8 index readback", 32'(r), 5);
    reg_rd(2'd1, r); chk("R8 reg5 readback", 32'(r), 32'h3C);
    reg_wr(2'd0, 8'd36); reg_wr(2'd1, 8'hA5);
    reg_rd(2'd1, r); chk("R8 reg36 readback", 32'(r), 32'hA5);

    // R9 out-of-range index
    reg_wr(2'd0, 8'd37); reg_wr(2'd1, 8'h77);
    reg_rd(2'd1, r); chk("R9 index 37 reads zero", 32'(r), 0);
    reg_wr(2'd0, 8'd40); reg_wr(2'd1, 8'h11);
    reg_rd(2'd1, r); chk("R9 index 40 reads zero", 32'(r), 0);
    reg_wr(2'd0, 8'd36);
    reg_rd(2'd1, r); chk("R9 reg36 untouched", 32'(r), 32'hA5);

    // R5 strobes without chip select or acknowledge
    bus(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd9, r, o);
    reg_rd(2'd0, r); chk("R5 index unchanged", 32'(r), 36);
    bus(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, r, o);
    chk("R5 data_oe low", 32'(o), 0);

    // R1 / R3 capture path, chip select low and address nonzero to show they are ignored
    cap_feed(8'h81); cap_feed(8'h42); cap_feed(8'hE7);
    repeat (2) @(negedge clk);
    chk("R1 cap_req after push", 32'(cap_req), 1);
    for (int i = 0; i < 3; i++) begin
      bus(1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 8'h00, r, o);
      chk("R3 capture byte", 32'(r), 32'(cap_q.pop_front()));
    end
    chk("R1 cap_req after drain", 32'(cap_req), 0);

    // R10 underrun
    bus(1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, r, o);
    chk("R10 repeat last byte", 32'(r), 32'hE7);
    reg_rd(2'd2, r); chk("R10 underrun flag", 32'(r), 32'h09);
    reg_wr(2'd2, 8'h01);
    reg_rd(2'd2, r); chk("R11 underrun cleared", 32'(r), 32'h08);

    // R4 / R2 / R11 playback path
    for (int i = 0; i < DEPTH; i++) begin
      pb_send(8'(8'h10 + i * 7), 1'b1);
      if (i == DEPTH - 2) chk("R2 pb_req one short", 32'(pb_req), 1);
    end
    chk("R2 pb_req when full", 32'(pb_req), 0);
    pb_send(8'hEE, 1'b0);
    reg_rd(2'd2, r); chk("R11 overrun flag", 32'(r), 32'h02);
    reg_wr(2'd2, 8'h02);
    reg_rd(2'd2, r); chk("R11 overrun cleared", 32'(r), 32'h00);

    @(posedge clk); #1; pb_out_ready = 1'b1;
    repeat (DEPTH + 10) @(posedge clk);
    @(negedge clk);
    chk("R4 bytes stored", 32'(drained), 32'(DEPTH));
    chk("R12 queue drained", 32'(pb_q.size()), 0);
    chk("R2 pb_req after drain", 32'(pb_req), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule